// File: doc/BRIEF.md
# Ethernet Destination Address Filter with Loadable CAM

This block decides whether a received frame is addressed to this station. The destination address arrives as a 48-bit value with a valid strobe, with the first byte on the wire in bits 7:0. One clock later the block returns a registered verdict: accept or reject, plus a broadcast or multicast flag. The decision follows a fixed priority. Promiscuous mode is checked first, then accept-all-multicast, then broadcast accept, and last an exact match against a 16-entry table of 48-bit addresses. Only table entries whose bit is set in a per-entry enable mask can match.

The table is never written directly. Instead, a load engine walks a list of descriptors in memory through a 16-bit read port that uses a request/valid handshake. For each pending count, the engine fills one table entry, starting at index 0. After the entries, it reads one more descriptor, which holds the enable mask. While the surrounding controller is held in reset, software can read any table entry back in three 16-bit parts.

Top module: `addr_filter_cam`

## Requirements
- R1: When `promisc_en` is high and bit 0 of `dst_addr` (the group bit) is 0, the frame is accepted with both flags low. This check ranks above all others.
- R2: When `all_mcast_en` is high and the group bit is 1, the frame is accepted with `is_mcast` high. This check ranks above the broadcast check, so an all-ones address under both enables reports multicast.
- R3: When `bcast_en` is high and all 48 address bits are 1, and neither R1 nor R2 applied, the frame is accepted with `is_bcast` high.
- R4: If no check above applies, the frame is accepted (flags low) only if it equals a table entry whose enable-mask bit is set. Otherwise it is rejected. A rejected frame never shows a flag, and at most one flag is ever high.
- R5: `verdict_valid` is high exactly in the cycle after a cycle with `dst_valid` high. `accept` and both flags are low whenever `verdict_valid` is low.
- R6: A load started with count N (the 5-bit `load_count`) fills entries 0, 1, … in order, with indices wrapping modulo 16. Descriptor words 1, 2 and 3 supply address bits 15:0, 31:16 and 47:32 respectively, so the low byte of each word is the lower-numbered address byte.
- R7: `wide_mode` is sampled at load start.
  - When it is 0, descriptor words are 2 bytes apart and descriptors are 8 bytes apart.
  - When it is 1, words are 4 bytes apart (the data sits in the low half of each 32-bit slot) and descriptors are 16 bytes apart.
- R8: After the N entries, the engine reads word 0 of the next descriptor as the 16-bit enable mask. With N = 0, only the mask is read. In the cycle after the mask read completes, `load_busy` falls and `load_done` pulses for one cycle.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_valid` returns data. Any read latency gives the same result.
- R10: While `in_reset` is high, `rb_data` returns part `rb_sel` of entry `rb_index`: 0 gives bits 15:0, 1 gives bits 31:16, 2 gives bits 47:32, and 3 gives zero.
- R11: While `in_reset` is low, `rb_data` is zero.
- R12: A `load_start` pulse while `load_busy` is high is ignored. The running load completes with its own base and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_reset | input | 1 | Controller is in reset; enables table readback |
| wide_mode | input | 1 | 32-bit descriptor layout when 1, 16-bit when 0 |
| promisc_en | input | 1 | Accept any individual (non-group) address |
| all_mcast_en | input | 1 | Accept any group address as multicast |
| bcast_en | input | 1 | Accept the all-ones address as broadcast |
| load_start | input | 1 | Start a table load (one-cycle pulse) |
| load_count | input | 5 | Number of entries to load |
| load_base | input | 32 | Byte address of the first descriptor |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle pulse when the load finishes |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested 16-bit word |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Read data |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first byte in bits 7:0 |
| verdict_valid | output | 1 | Verdict valid, one cycle after the strobe |
| accept | output | 1 | Frame accepted |
| is_bcast | output | 1 | Accepted as broadcast |
| is_mcast | output | 1 | Accepted as multicast |
| rb_index | input | 4 | Table entry to read back |
| rb_sel | input | 2 | Address part to read back |
| rb_data | output | 16 | Readback data |

## Verification
Some internal faults show up immediately. A wrong byte placement or a wrong entry index in the table appears on `rb_data` in the same cycle the entry is selected under reset. A misplaced descriptor pointer or word spacing appears on `mem_addr` at the very next request.

Other faults need a probe to surface. A stale or wrongly captured enable mask, or a broken priority order, is visible only through `accept` and the flags, one cycle after a probe strobe. For that reason, each load is followed by probes of both enabled and disabled entries.

A stuck load state shows up as `load_busy` never falling. The bench catches it with a bounded wait for `load_done`.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int HALF_W    = 16;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_ENTRY,
    LD_MASK
  } ld_state_e;

  typedef struct packed {
    logic accept;
    logic bcast;
    logic mcast;
  } verdict_t;

  // Group (multicast) bit: bit 0 of the first byte on the wire.
  function automatic logic group_bit(input logic [MAC_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic all_ones(input logic [MAC_W-1:0] a);
    return &a;
  endfunction

  // Byte offset of descriptor word w inside one descriptor.
  function automatic logic [4:0] word_offset(input logic [1:0] w, input logic wide);
    return wide ? {1'b0, w, 2'b00} : {2'b00, w, 1'b0};
  endfunction

  // Byte distance between consecutive descriptors.
  function automatic logic [4:0] desc_stride(input logic wide);
    return wide ? 5'd16 : 5'd8;
  endfunction

  // Fixed priority decision: promiscuous, all-multicast, broadcast, table hit.
  function automatic verdict_t decide(input logic promisc, input logic allmc,
                                      input logic bcen, input logic hit,
                                      input logic [MAC_W-1:0] a);
    verdict_t v;
    v = '0;
    if (promisc && !group_bit(a)) begin
      v.accept = 1'b1;
    end else if (allmc && group_bit(a)) begin
      v.accept = 1'b1;
      v.mcast  = 1'b1;
    end else if (bcen && all_ones(a)) begin
      v.accept = 1'b1;
      v.bcast  = 1'b1;
    end else if (hit) begin
      v.accept = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/afc_cam_table.sv
module afc_cam_table
  import afc_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [1:0]                 wr_part,
  input  logic [HALF_W-1:0]          wr_data,
  input  logic                       mask_wr,
  input  logic [ENTRIES-1:0]         mask_data,
  input  logic [MAC_W-1:0]           lookup,
  output logic                       hit,
  input  logic                       rb_en,
  input  logic [$clog2(ENTRIES)-1:0] rb_idx,
  input  logic [1:0]                 rb_part,
  output logic [HALF_W-1:0]          rb_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [MAC_W-1:0]   ent [ENTRIES];
  logic [ENTRIES-1:0] en_mask;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        case (wr_part)
          2'd0:    ent[g][15:0]  <= wr_data;
          2'd1:    ent[g][31:16] <= wr_data;
          2'd2:    ent[g][47:32] <= wr_data;
          default: ent[g]        <= ent[g];
        endcase
      end
    end
    assign match[g] = en_mask[g] && (ent[g] == lookup);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_mask <= '0;
    else if (mask_wr) en_mask <= mask_data;
  end

  assign hit = |match;

  always_comb begin
    rb_data = '0;
    if (rb_en) begin
      case (rb_part)
        2'd0:    rb_data = ent[rb_idx][15:0];
        2'd1:    rb_data = ent[rb_idx][31:16];
        2'd2:    rb_data = ent[rb_idx][47:32];
        default: rb_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/afc_load_engine.sv
module afc_load_engine
  import afc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int MADDR_W = 32,
  parameter int CNT_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CNT_W-1:0]           count,
  input  logic [MADDR_W-1:0]         base,
  input  logic                       wide,
  output logic                       mem_req,
  output logic [MADDR_W-1:0]         mem_addr,
  input  logic                       mem_valid,
  input  logic [HALF_W-1:0]          mem_rdata,
  output logic                       busy,
  output logic                       done,
  output logic                       wr_en,
  output logic [$clog2(ENTRIES)-1:0] wr_idx,
  output logic [1:0]                 wr_part,
  output logic [HALF_W-1:0]          wr_data,
  output logic                       mask_wr,
  output logic [ENTRIES-1:0]         mask_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  ld_state_e          st;
  logic [CNT_W-1:0]   cnt;
  logic [MADDR_W-1:0] ptr;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         word;
  logic               wide_q;
  logic               done_q;
  logic               last_word;

  assign last_word = (word == 2'd3);

  always_comb begin
    mem_req   = (st != LD_IDLE);
    mem_addr  = ptr + ((st == LD_ENTRY) ? MADDR_W'(word_offset(word, wide_q)) : '0);
    wr_en     = (st == LD_ENTRY) && mem_valid;
    wr_idx    = idx;
    wr_part   = word - 2'd1;
    wr_data   = mem_rdata;
    mask_wr   = (st == LD_MASK) && mem_valid;
    mask_data = mem_rdata[ENTRIES-1:0];
    busy      = (st != LD_IDLE);
    done      = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LD_IDLE;
      cnt    <= '0;
      ptr    <= '0;
      idx    <= '0;
      word   <= 2'd1;
      wide_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        LD_IDLE: begin
          if (start) begin
            cnt    <= count;
            ptr    <= base;
            idx    <= '0;
            word   <= 2'd1;
            wide_q <= wide;
            st     <= (count == '0) ? LD_MASK : LD_ENTRY;
          end
        end
        LD_ENTRY: begin
          if (mem_valid) begin
            if (last_word) begin
              word <= 2'd1;
              cnt  <= cnt - CNT_W'(1);
              ptr  <= ptr + MADDR_W'(desc_stride(wide_q));
              idx  <= idx + IDX_W'(1);
              if (cnt == CNT_W'(1)) st <= LD_MASK;
            end else begin
              word <= word + 2'd1;
            end
          end
        end
        LD_MASK: begin
          if (mem_valid) begin
            st     <= LD_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/afc_filter_stage.sv
module afc_filter_stage
  import afc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dst_valid,
  input  logic [MAC_W-1:0] dst_addr,
  input  logic             promisc_en,
  input  logic             all_mcast_en,
  input  logic             bcast_en,
  input  logic             cam_hit,
  output logic             verdict_valid,
  output logic             accept,
  output logic             is_bcast,
  output logic             is_mcast
);
  verdict_t nxt;
  verdict_t v_q;
  logic     vld_q;

  assign nxt = decide(promisc_en, all_mcast_en, bcast_en, cam_hit, dst_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      v_q   <= '0;
    end else begin
      vld_q <= dst_valid;
      v_q   <= dst_valid ? nxt : '0;
    end
  end

  assign verdict_valid = vld_q;
  assign accept        = v_q.accept;
  assign is_bcast      = v_q.bcast;
  assign is_mcast      = v_q.mcast;
endmodule

// File: rtl/addr_filter_cam.sv
module addr_filter_cam
  import afc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int MADDR_W = 32,
  parameter int CNT_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_reset,
  input  logic                       wide_mode,
  input  logic                       promisc_en,
  input  logic                       all_mcast_en,
  input  logic                       bcast_en,
  input  logic                       load_start,
  input  logic [CNT_W-1:0]           load_count,
  input  logic [MADDR_W-1:0]         load_base,
  output logic                       load_busy,
  output logic                       load_done,
  output logic                       mem_req,
  output logic [MADDR_W-1:0]         mem_addr,
  input  logic                       mem_valid,
  input  logic [15:0]                mem_rdata,
  input  logic                       dst_valid,
  input  logic [47:0]                dst_addr,
  output logic                       verdict_valid,
  output logic                       accept,
  output logic                       is_bcast,
  output logic                       is_mcast,
  input  logic [$clog2(ENTRIES)-1:0] rb_index,
  input  logic [1:0]                 rb_sel,
  output logic [15:0]                rb_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  // Internal events, brought out by name for the checker.
  logic              cam_wr_en;
  logic [IDX_W-1:0]  cam_wr_idx;
  logic [1:0]        cam_wr_part;
  logic [HALF_W-1:0] cam_wr_data;
  logic              mask_wr;
  logic [ENTRIES-1:0] mask_data;
  logic              cam_hit;

  afc_load_engine #(
    .ENTRIES(ENTRIES), .MADDR_W(MADDR_W), .CNT_W(CNT_W)
  ) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (load_start),
    .count     (load_count),
    .base      (load_base),
    .wide      (wide_mode),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_rdata (mem_rdata),
    .busy      (load_busy),
    .done      (load_done),
    .wr_en     (cam_wr_en),
    .wr_idx    (cam_wr_idx),
    .wr_part   (cam_wr_part),
    .wr_data   (cam_wr_data),
    .mask_wr   (mask_wr),
    .mask_data (mask_data)
  );

  afc_cam_table #(.ENTRIES(ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cam_wr_en),
    .wr_idx    (cam_wr_idx),
    .wr_part   (cam_wr_part),
    .wr_data   (cam_wr_data),
    .mask_wr   (mask_wr),
    .mask_data (mask_data),
    .lookup    (dst_addr),
    .hit       (cam_hit),
    .rb_en     (in_reset),
    .rb_idx    (rb_index),
    .rb_part   (rb_sel),
    .rb_data   (rb_data)
  );

  afc_filter_stage u_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .dst_valid     (dst_valid),
    .dst_addr      (dst_addr),
    .promisc_en    (promisc_en),
    .all_mcast_en  (all_mcast_en),
    .bcast_en      (bcast_en),
    .cam_hit       (cam_hit),
    .verdict_valid (verdict_valid),
    .accept        (accept),
    .is_bcast      (is_bcast),
    .is_mcast      (is_mcast)
  );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int MADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dst_valid,
  input logic               verdict_valid,
  input logic               accept,
  input logic               is_bcast,
  input logic               is_mcast,
  input logic               in_reset,
  input logic [15:0]        rb_data,
  input logic               mem_req,
  input logic               mem_valid,
  input logic [MADDR_W-1:0] mem_addr,
  input logic               load_start,
  input logic               load_busy,
  input logic               load_done,
  input logic               cam_wr_en
);
  a_r5_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> verdict_valid);

  a_r5_no_stray_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !verdict_valid);

  a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !accept);

  a_r4_flags_need_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bcast || is_mcast) |-> accept);

  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_bcast, is_mcast}));

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  a_r11_rb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reset |-> (rb_data == 16'h0000));

  a_r8_done_ends_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!load_busy && $past(load_busy)));

  a_r6_write_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    cam_wr_en |-> load_busy);

  a_r12_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_start && !load_busy) |=> load_busy);
endmodule

bind addr_filter_cam afc_checker #(.MADDR_W(MADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dst_valid     (dst_valid),
  .verdict_valid (verdict_valid),
  .accept        (accept),
  .is_bcast      (is_bcast),
  .is_mcast      (is_mcast),
  .in_reset      (in_reset),
  .rb_data       (rb_data),
  .mem_req       (mem_req),
  .mem_valid     (mem_valid),
  .mem_addr      (mem_addr),
  .load_start    (load_start),
  .load_busy     (load_busy),
  .load_done     (load_done),
  .cam_wr_en     (cam_wr_en)
);

// File: tb/addr_filter_cam_test.sv
module addr_filter_cam_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_reset = 1'b1;
  logic        wide_mode = 1'b0;
  logic        promisc_en = 1'b0;
  logic        all_mcast_en = 1'b0;
  logic        bcast_en = 1'b0;
  logic        load_start = 1'b0;
  logic [4:0]  load_count = '0;
  logic [31:0] load_base = '0;
  logic        load_busy, load_done, mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        verdict_valid, accept, is_bcast, is_mcast;
  logic [3:0]  rb_index = '0;
  logic [1:0]  rb_sel = '0;
  logic [15:0] rb_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] mem [0:1023];

  localparam logic [47:0] MAC_A  = 48'h1234_5678_9A02;
  localparam logic [47:0] MAC_B  = 48'h0000_0000_0B04;
  localparam logic [47:0] MAC_C  = 48'h3344_5566_7706;
  localparam logic [47:0] MAC_D  = 48'hCAFE_F00D_BE08;
  localparam logic [47:0] MAC_E  = 48'h0102_0304_050A;
  localparam logic [47:0] MAC_F  = 48'h1111_2222_330C;
  localparam logic [47:0] MAC_G  = 48'h4444_5555_660E;
  localparam logic [47:0] MAC_U  = 48'h0000_0000_0010;
  localparam logic [47:0] MAC_M  = 48'h0000_5E00_0101;
  localparam logic [47:0] MAC_BC = 48'hFFFF_FFFF_FFFF;

  always #2 clk = ~clk;

  addr_filter_cam uut (
    .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .wide_mode(wide_mode),
    .promisc_en(promisc_en), .all_mcast_en(all_mcast_en), .bcast_en(bcast_en),
    .load_start(load_start), .load_count(load_count), .load_base(load_base),
    .load_busy(load_busy), .load_done(load_done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .verdict_valid(verdict_valid),
    .accept(accept), .is_bcast(is_bcast), .is_mcast(is_mcast),
    .rb_index(rb_index), .rb_sel(rb_sel), .rb_data(rb_data)
  );

  // Memory responder with latency cycling through 0..3 extra cycles.
  initial begin : responder
    int lat;
    int waited;
    lat = 0;
    waited = 0;
    forever begin
      @(negedge clk);
      if (mem_valid) begin
        mem_valid = 1'b0;
      end else if (mem_req) begin
        if (waited >= lat) begin
          mem_rdata = mem[mem_addr[10:1]];
          mem_valid = 1'b1;
          waited = 0;
          lat = (lat + 1) % 4;
        end else begin
          waited++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] a, input logic [15:0] d);
    mem[a[10:1]] = d;
  endtask

  task automatic put_desc(input logic [31:0] base, input bit wide, input int i,
                          input logic [47:0] mac);
    logic [31:0] d;
    int sp;
    sp = wide ? 4 : 2;
    d = base + 32'(i * (wide ? 16 : 8));
    put_word(d + 32'(sp * 1), mac[15:0]);
    put_word(d + 32'(sp * 2), mac[31:16]);
    put_word(d + 32'(sp * 3), mac[47:32]);
  endtask

  task automatic put_mask(input logic [31:0] base, input bit wide, input int cnt,
                          input logic [15:0] m);
    put_word(base + 32'(cnt * (wide ? 16 : 8)), m);
  endtask

  task automatic run_load(input logic [31:0] base, input int cnt, input bit wide,
                          input string req);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    wide_mode = wide;
    load_base = base;
    load_count = 5'(cnt);
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    for (int k = 0; k < 500 && !seen; k++) begin
      if (load_done) seen = 1'b1;
      else @(negedge clk);
    end
    chk({req, " load done with busy low"}, {62'd0, seen, load_busy}, {62'd0, 1'b1, 1'b0});
  endtask

  task automatic probe(input logic [47:0] mac, input bit acc, input bit bc,
                       input bit mc, input string req);
    @(negedge clk);
    dst_valid = 1'b1;
    dst_addr = mac;
    @(negedge clk);
    dst_valid = 1'b0;
    chk(req, {60'd0, verdict_valid, accept, is_bcast, is_mcast},
        {60'd0, 1'b1, acc, bc, mc});
  endtask

  task automatic rb_check(input int idx, input int sel, input logic [15:0] exp,
                          input string req);
    @(negedge clk);
    rb_index = 4'(idx);
    rb_sel = 2'(sel);
    #1;
    chk(req, {48'd0, rb_data}, {48'd0, exp});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk("R5 reset verdict", {61'd0, verdict_valid, accept, is_bcast}, 64'd0);
    chk("R8 reset busy", {62'd0, load_busy, mem_req}, 64'd0);
    rb_check(0, 0, 16'h0000, "R10 empty table readback");
  endtask

  task automatic t_load_narrow;
    put_desc(32'h40, 1'b0, 0, MAC_A);
    put_desc(32'h40, 1'b0, 1, MAC_B);
    put_desc(32'h40, 1'b0, 2, MAC_C);
    put_mask(32'h40, 1'b0, 3, 16'h0005);
    run_load(32'h40, 3, 1'b0, "R8 narrow");
    rb_check(0, 0, MAC_A[15:0], "R6 R10 entry0 part0");
    rb_check(0, 1, MAC_A[31:16], "R6 R10 entry0 part1");
    rb_check(0, 2, MAC_A[47:32], "R6 R10 entry0 part2");
    rb_check(1, 0, MAC_B[15:0], "R6 entry1 part0");
    rb_check(2, 2, MAC_C[47:32], "R6 entry2 part2");
    probe(MAC_A, 1'b1, 1'b0, 1'b0, "R4 enabled entry0 hit");
    probe(MAC_B, 1'b0, 1'b0, 1'b0, "R4 disabled entry1 rejected");
    probe(MAC_C, 1'b1, 1'b0, 1'b0, "R4 enabled entry2 hit");
    probe(MAC_U, 1'b0, 1'b0, 1'b0, "R4 unknown address rejected");
  endtask

  task automatic t_load_wide;
    put_desc(32'h200, 1'b1, 0, MAC_D);
    put_desc(32'h200, 1'b1, 1, MAC_E);
    put_mask(32'h200, 1'b1, 2, 16'h0002);
    run_load(32'h200, 2, 1'b1, "R8 wide");
    rb_check(0, 0, MAC_D[15:0], "R7 wide entry0 part0");
    rb_check(0, 2, MAC_D[47:32], "R7 wide entry0 part2");
    rb_check(1, 1, MAC_E[31:16], "R7 wide entry1 part1");
    rb_check(2, 0, MAC_C[15:0], "R6 entry2 untouched");
    probe(MAC_E, 1'b1, 1'b0, 1'b0, "R7 wide entry1 hit");
    probe(MAC_D, 1'b0, 1'b0, 1'b0, "R8 new mask disables entry0");
    probe(MAC_C, 1'b0, 1'b0, 1'b0, "R8 new mask disables entry2");
  endtask

  task automatic t_count_zero;
    put_mask(32'h300, 1'b0, 0, 16'h0001);
    run_load(32'h300, 0, 1'b0, "R8 count zero");
    rb_check(0, 0, MAC_D[15:0], "R8 count zero keeps entry0");
    probe(MAC_D, 1'b1, 1'b0, 1'b0, "R8 mask-only load enables entry0");
    probe(MAC_E, 1'b0, 1'b0, 1'b0, "R8 mask-only load disables entry1");
  endtask

  task automatic t_priority;
    promisc_en = 1'b1;
    probe(MAC_U, 1'b1, 1'b0, 1'b0, "R1 promiscuous unicast");
    probe(MAC_M, 1'b0, 1'b0, 1'b0, "R1 promiscuous skips group address");
    promisc_en = 1'b0;
    all_mcast_en = 1'b1;
    probe(MAC_M, 1'b1, 1'b0, 1'b1, "R2 all-multicast");
    bcast_en = 1'b1;
    probe(MAC_BC, 1'b1, 1'b0, 1'b1, "R2 multicast outranks broadcast");
    all_mcast_en = 1'b0;
    probe(MAC_BC, 1'b1, 1'b1, 1'b0, "R3 broadcast accept");
    promisc_en = 1'b1;
    probe(MAC_BC, 1'b1, 1'b1, 1'b0, "R3 broadcast under promiscuous");
    promisc_en = 1'b0;
    bcast_en = 1'b0;
    probe(MAC_BC, 1'b0, 1'b0, 1'b0, "R3 broadcast rejected when disabled");
  endtask

  task automatic t_verdict_timing;
    probe(MAC_D, 1'b1, 1'b0, 1'b0, "R5 verdict one cycle after strobe");
    @(negedge clk);
    chk("R5 verdict drops after one cycle", {62'd0, verdict_valid, accept}, 64'd0);
  endtask

  task automatic t_readback_gate;
    in_reset = 1'b0;
    rb_check(0, 0, 16'h0000, "R11 readback zero outside reset");
    rb_check(1, 1, 16'h0000, "R11 readback zero outside reset part1");
    in_reset = 1'b1;
    rb_check(0, 3, 16'h0000, "R10 part select 3 reads zero");
  endtask

  task automatic t_busy_ignore;
    bit seen;
    seen = 1'b0;
    put_desc(32'h100, 1'b0, 0, MAC_F);
    put_mask(32'h100, 1'b0, 1, 16'h0001);
    put_desc(32'h180, 1'b0, 0, MAC_G);
    put_mask(32'h180, 1'b0, 1, 16'h0001);
    @(negedge clk);
    wide_mode = 1'b0;
    load_base = 32'h100;
    load_count = 5'd1;
    load_start = 1'b1;
    @(negedge clk);
    load_base = 32'h180;
    chk("R12 busy after start", {63'd0, load_busy}, 64'd1);
    @(negedge clk);
    load_start = 1'b0;
    for (int k = 0; k < 500 && !seen; k++) begin
      if (load_done) seen = 1'b1;
      else @(negedge clk);
    end
    chk("R12 first load completes", {63'd0, seen}, 64'd1);
    rb_check(0, 0, MAC_F[15:0], "R12 entry from first load");
    probe(MAC_F, 1'b1, 1'b0, 1'b0, "R12 first load address hits");
    probe(MAC_G, 1'b0, 1'b0, 1'b0, "R12 second start ignored");
  endtask

  initial begin : watchdog
    #(4 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = 16'hA5A5 ^ 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_load_narrow();
    t_load_wide();
    t_count_zero();
    t_priority();
    t_verdict_timing();
    t_readback_gate();
    t_busy_ignore();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule